// File: doc/BRIEF.md
# Two-Operand NaN Propagation Selector

This unit sits in front of a two-operand floating-point datapath. It looks at both operands and decides whether the result has to be a NaN. If either operand is a NaN, it raises a done flag. The datapath then discards its own arithmetic result and takes the NaN word this unit provides. The unit also raises an invalid-operation flag whenever a signalling NaN is present. The arithmetic itself happens elsewhere.

A format parameter selects single precision (32-bit word: 8 exponent bits, 23 fraction bits) or double precision (64-bit word: 11 exponent bits, 52 fraction bits). The bit layout is the usual one: sign in the top bit, the exponent field next, and the fraction field in the low bits. The quiet bit is the most significant fraction bit. The canonical quiet NaN is 0x7FC00000 in single precision and 0x7FF8000000000000 in double precision.

The unit is purely combinational. It has no clock, no handshake and no storage. The outputs follow the inputs within the same cycle, so they can be registered together with the datapath result by whatever stage consumes them. The operands are plain status-free words, so no valid/ready pair is involved. The caller holds the operands for as long as it needs the answer.

Top module: `nan_prop_sel`

## Requirements
- R1: An operand counts as a NaN exactly when its exponent field is all ones and its fraction field is nonzero. An all-ones exponent with a zero fraction (an infinity) is not a NaN.
- R2: When neither operand is a NaN, `bypass_done` is 0, `invalid_op` is 0 and `nan_out` is all zeros, whatever the value of `dflt_nan_en`.
- R3: When at least one operand is a NaN and `dflt_nan_en` is 1, `nan_out` is the canonical quiet NaN: sign 0, exponent all ones, only the fraction MSB set.
- R4: With `dflt_nan_en` at 0 and `opnd_a` a signalling NaN (fraction MSB 0), `nan_out` is `opnd_a` with its fraction MSB forced to 1. Sign and payload are kept, and this holds whatever `opnd_b` is.
- R5: With `dflt_nan_en` at 0, `opnd_a` not signalling and `opnd_b` a signalling NaN, `nan_out` is `opnd_b` with its fraction MSB forced to 1. This holds even when `opnd_a` is a quiet NaN.
- R6: With `dflt_nan_en` at 0, neither operand signalling and `opnd_a` a quiet NaN (fraction MSB 1), `nan_out` equals `opnd_a` bit for bit.
- R7: With `dflt_nan_en` at 0, neither operand signalling, `opnd_a` not a NaN and `opnd_b` a quiet NaN, `nan_out` equals `opnd_b` bit for bit.
- R8: `invalid_op` is 1 exactly when at least one operand is a signalling NaN, regardless of `dflt_nan_en`.
- R9: `bypass_done` is 1 exactly when at least one operand is a NaN. Whenever it is 1, `nan_out` is itself a quiet NaN.
- R10: With the format parameter set to double precision, R1 to R9 hold on 64-bit words with an 11-bit exponent and a 52-bit fraction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | W (32 or 64) | First operand; wins ties of equal NaN class |
| opnd_b | input | W (32 or 64) | Second operand |
| dflt_nan_en | input | 1 | 1: any NaN result becomes the canonical quiet NaN |
| nan_out | output | W (32 or 64) | NaN word to substitute; zero when no NaN is present |
| bypass_done | output | 1 | 1: datapath must take `nan_out` instead of its own result |
| invalid_op | output | 1 | 1: a signalling NaN was seen |

## Verification
Each operand is swept over twelve class representatives, in every pair, with the default-NaN mode both off and on, in both formats. The representatives are signed zeros, a normal, a subnormal, both infinities, quiet NaNs with minimal and maximal payloads, and signalling NaNs with minimal, maximal and mid payloads.

The infinity cases separate a correct NaN test from one that checks only the exponent field. Signalling-against-quiet pairs in both orders show whether signalling status outranks operand position. Mixed-sign, mixed-payload pairs show whether the chosen operand keeps its sign and payload while only the quiet bit changes. Sweeping the mode bit shows that the invalid flag does not depend on the mode.

// File: rtl/fp_nan_pkg.sv
package fp_nan_pkg;

  typedef enum logic {
    FMT_SP = 1'b0,
    FMT_DP = 1'b1
  } fp_fmt_e;

  function automatic int unsigned fmt_exp_w(fp_fmt_e f);
    return (f == FMT_DP) ? 11 : 8;
  endfunction

  function automatic int unsigned fmt_frac_w(fp_fmt_e f);
    return (f == FMT_DP) ? 52 : 23;
  endfunction

  // Operand slot order doubles as priority order: slot 0 is the first operand.
  localparam int unsigned NUM_OPND = 2;

endpackage

// File: rtl/nan_classify.sv
module nan_classify #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] word_i,
  output logic         is_nan_o,
  output logic         is_sig_o,
  output logic [W-1:0] quiet_o
);

  localparam logic [W-1:0] QMASK = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;
  logic              frac_nz;

  assign exp_f    = word_i[FRAC_W +: EXP_W];
  assign frac_f   = word_i[FRAC_W-1:0];
  assign exp_ones = &exp_f;
  assign frac_nz  = |frac_f;

  always_comb begin
    is_nan_o = exp_ones && frac_nz;
    is_sig_o = is_nan_o && ((word_i & QMASK) != QMASK);
    quiet_o  = word_i | QMASK;
  end

endmodule

// File: rtl/nan_pick.sv
module nan_pick #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic [1:0]        is_nan_i,
  input  logic [1:0]        is_sig_i,
  input  logic [1:0][W-1:0] raw_i,
  input  logic [1:0][W-1:0] quiet_i,
  input  logic              dflt_i,
  output logic [W-1:0]      res_o,
  output logic              done_o,
  output logic              inv_o
);

  localparam logic [W-1:0] CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  always_comb begin
    done_o = |is_nan_i;
    inv_o  = |is_sig_i;
    res_o  = '0;
    if (done_o) begin
      if (dflt_i)           res_o = CANON;
      else if (is_sig_i[0]) res_o = quiet_i[0];
      else if (is_sig_i[1]) res_o = quiet_i[1];
      else if (is_nan_i[0]) res_o = raw_i[0];
      else                  res_o = raw_i[1];
    end
  end

endmodule

// File: rtl/nan_prop_sel.sv
module nan_prop_sel
  import fp_nan_pkg::*;
#(
  parameter fp_fmt_e FMT        = FMT_SP,
  localparam int unsigned EXP_W  = fmt_exp_w(FMT),
  localparam int unsigned FRAC_W = fmt_frac_w(FMT),
  localparam int unsigned W      = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         dflt_nan_en,
  output logic [W-1:0] nan_out,
  output logic         bypass_done,
  output logic         invalid_op
);

  logic [NUM_OPND-1:0]        nan_v;
  logic [NUM_OPND-1:0]        sig_v;
  logic [NUM_OPND-1:0][W-1:0] raw_v;
  logic [NUM_OPND-1:0][W-1:0] qui_v;

  assign raw_v[0] = opnd_a;
  assign raw_v[1] = opnd_b;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_cls
    nan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word_i   (raw_v[g]),
      .is_nan_o (nan_v[g]),
      .is_sig_o (sig_v[g]),
      .quiet_o  (qui_v[g])
    );
  end

  nan_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pick (
    .is_nan_i (nan_v),
    .is_sig_i (sig_v),
    .raw_i    (raw_v),
    .quiet_i  (qui_v),
    .dflt_i   (dflt_nan_en),
    .res_o    (nan_out),
    .done_o   (bypass_done),
    .inv_o    (invalid_op)
  );

endmodule

// File: rtl/nan_prop_sel_chk.sv
module nan_prop_sel_chk #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         dflt_nan_en,
  input logic [W-1:0] nan_out,
  input logic         bypass_done,
  input logic         invalid_op
);

  localparam logic [W-1:0] CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic out_is_quiet;
  logic a_nan;
  logic b_nan;
  assign out_is_quiet = (&nan_out[FRAC_W +: EXP_W]) && nan_out[FRAC_W-1];
  assign a_nan = (&opnd_a[FRAC_W +: EXP_W]) && (|opnd_a[FRAC_W-1:0]);
  assign b_nan = (&opnd_b[FRAC_W +: EXP_W]) && (|opnd_b[FRAC_W-1:0]);

  always_comb begin
    // R2: without a NaN the outputs are clean
    p_clean_idle_r2: assert (bypass_done || (nan_out == '0 && !invalid_op));
    // R3: default mode gives the canonical word
    p_canon_dflt_r3: assert (!(bypass_done && dflt_nan_en) || nan_out == CANON);
    // R4: a chosen operand differs from the output at most in the quiet bit
    p_from_operand_r4: assert (!bypass_done || dflt_nan_en ||
                               (nan_out | CANON) == (opnd_a | CANON) ||
                               (nan_out | CANON) == (opnd_b | CANON));
    // R8: invalid only alongside a NaN
    p_inv_needs_nan_r8: assert (!invalid_op || bypass_done);
    // R9: done tracks NaN presence and output is quiet
    p_done_quiet_r9: assert (!bypass_done || out_is_quiet);
    p_done_match_r9: assert (bypass_done == (a_nan || b_nan));
  end

endmodule

bind nan_prop_sel nan_prop_sel_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .opnd_a      (opnd_a),
  .opnd_b      (opnd_b),
  .dflt_nan_en (dflt_nan_en),
  .nan_out     (nan_out),
  .bypass_done (bypass_done),
  .invalid_op  (invalid_op)
);

// File: tb/tb_nan_prop_sel.sv
module tb_nan_prop_sel;
  import fp_nan_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [31:0] sa, sb, sr;
  logic [63:0] da, db, dr;
  logic        sdn, ddn, sdone, ddone, sinv, dinv;

  nan_prop_sel #(.FMT(FMT_SP)) dut (
    .opnd_a(sa), .opnd_b(sb), .dflt_nan_en(sdn),
    .nan_out(sr), .bypass_done(sdone), .invalid_op(sinv));

  nan_prop_sel #(.FMT(FMT_DP)) dut_dp (
    .opnd_a(da), .opnd_b(db), .dflt_nan_en(ddn),
    .nan_out(dr), .bypass_done(ddone), .invalid_op(dinv));

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit finished = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <=100000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  function automatic logic [63:0] mk(int e, int f, bit s, logic [63:0] ex, logic [63:0] fr);
    return ({63'd0, s} << (e + f)) | (ex << f) | fr;
  endfunction

  // Twelve class representatives per format
  function automatic logic [63:0] pat(int idx, int e, int f);
    logic [63:0] eones = (64'd1 << e) - 1;
    logic [63:0] fones = (64'd1 << f) - 1;
    logic [63:0] qb    = 64'd1 << (f - 1);
    case (idx)
      0:  return mk(e, f, 0, 0, 0);                       // +0
      1:  return mk(e, f, 1, 0, 0);                       // -0
      2:  return mk(e, f, 0, eones >> 1, 0);              // +1.0
      3:  return mk(e, f, 1, 0, 1);                       // -subnormal
      4:  return mk(e, f, 0, eones, 0);                   // +inf (R1)
      5:  return mk(e, f, 1, eones, 0);                   // -inf (R1)
      6:  return mk(e, f, 0, eones, qb);                  // canonical qNaN
      7:  return mk(e, f, 1, eones, qb | 5);              // -qNaN payload
      8:  return mk(e, f, 0, eones, fones);               // qNaN max payload
      9:  return mk(e, f, 0, eones, 1);                   // sNaN min
      10: return mk(e, f, 1, eones, fones ^ qb);          // -sNaN max payload
      default: return mk(e, f, 1, eones, qb >> 1);        // -sNaN mid
    endcase
  endfunction

  task automatic expect_of(int e, int f, logic [63:0] a, logic [63:0] b, bit dn,
                           output logic [63:0] r, output bit dn_o, output bit inv,
                           output string req);
    logic [63:0] em = ((64'd1 << e) - 1) << f;
    logic [63:0] fm = (64'd1 << f) - 1;
    logic [63:0] qb = 64'd1 << (f - 1);
    bit na = ((a & em) == em) && ((a & fm) != 0);
    bit nb = ((b & em) == em) && ((b & fm) != 0);
    bit sga = na && ((a & qb) == 0);
    bit sgb = nb && ((b & qb) == 0);
    dn_o = na || nb;
    inv  = sga || sgb;
    r    = 0;
    if (!dn_o)      begin req = "R2 (R1)"; end
    else if (dn)    begin r = em | qb; req = "R3"; end
    else if (sga)   begin r = a | qb;  req = "R4"; end
    else if (sgb)   begin r = b | qb;  req = "R5"; end
    else if (na)    begin r = a;       req = "R6"; end
    else            begin r = b;       req = "R7"; end
    if (inv) req = {req, "/R8"};
  endtask

  task automatic check(string fmt, string req, logic [63:0] act_r, bit act_d, bit act_i,
                       logic [63:0] exp_r, bit exp_d, bit exp_i);
    n_vec++;
    if (act_r !== exp_r || act_d !== exp_d || act_i !== exp_i) begin
      n_bad++;
      $display("FAIL %s %s: actual res=%h done=%0b inv=%0b expected res=%h done=%0b inv=%0b (R9)",
               fmt, req, act_r, act_d, act_i, exp_r, exp_d, exp_i);
    end
  endtask

  initial begin
    logic [63:0] er;
    bit ed, ei;
    string rq;
    sa = '0; sb = '0; sdn = 1'b0;
    da = '0; db = '0; ddn = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state: zero operands give clean outputs (R2)
    check("SP", "R2 reset", {32'd0, sr}, sdone, sinv, 64'd0, 0, 0);
    check("DP", "R2 reset R10", dr, ddone, dinv, 64'd0, 0, 0);

    for (int dn = 0; dn < 2; dn++) begin
      for (int ia = 0; ia < 12; ia++) begin
        for (int ib = 0; ib < 12; ib++) begin
          @(posedge clk);
          sa = pat(ia, 8, 23); sb = pat(ib, 8, 23); sdn = dn[0];
          da = pat(ia, 11, 52); db = pat(ib, 11, 52); ddn = dn[0];
          @(negedge clk);
          expect_of(8, 23, {32'd0, sa}, {32'd0, sb}, dn[0], er, ed, ei, rq);
          check("SP", rq, {32'd0, sr}, sdone, sinv, er, ed, ei);
          expect_of(11, 52, da, db, dn[0], er, ed, ei, rq);
          check("DP", {rq, " R10"}, dr, ddone, dinv, er, ed, ei);
        end
      end
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule